// File: doc/BRIEF.md
# Page-Relative Conditional Branch Unit

This block resolves conditional jumps for a small 8-bit controller core. On each request it evaluates one of fourteen branch tests and returns the next program counter one clock later. The tests cover the accumulator, carry, two user flags, the timer flag, two external test pins and the two host-interface buffer flags. A taken jump keeps the page bits of the program counter and replaces only the low byte with the 8-bit target. The jump therefore always lands inside a 256-location page. A jump that is not taken falls through past its two-byte instruction.

The core presents `pc_in` as the address of the jump opcode. It presents `target` as the operand byte, which is fetched from `pc_in + 1`. The page is taken from the address of that operand byte. The two test pins are asynchronous to the core, so each one passes through a two-flop synchroniser before any test reads it.

The control is a two-state machine:
- **ST_IDLE**: no result is pending.
- **ST_RESOLVE**: a registered result is presented with `done` high.

The transitions are:
- **T_ACCEPT** (ST_IDLE to ST_RESOLVE) on `req`.
- **T_CHAIN** (ST_RESOLVE to ST_RESOLVE) on `req`, for a back-to-back request.
- **T_RETIRE** (ST_RESOLVE to ST_IDLE) when `req` is low.
- **T_WAIT** (ST_IDLE to ST_IDLE) when `req` is low.

Top module: `pgbr_unit`

## Requirements
- R1: When the condition holds, `next_pc` is `{(pc_in+1)[11:8], target}`. The page is that of the operand byte, so `pc_in = 0x0FF` jumps into page 0x1 and `pc_in = 0xFFF` jumps into page 0x0.
- R2: When the condition fails, `next_pc` is `(pc_in + 2) mod 4096`, and `taken` is 0.
- R3: `cond_sel` 0 is taken when `acc == 0`. `cond_sel` 1 is taken when `acc != 0`.
- R4: `cond_sel` 2 is taken when `acc[bit_idx]` is 1, where `bit_idx` 0 selects the least significant bit.
- R5: `cond_sel` 3 is taken when `carry` is 1. `cond_sel` 4 is taken when `carry` is 0.
- R6: `cond_sel` 5 is taken when `uflag0` is 1, `cond_sel` 6 when `uflag1` is 1, and `cond_sel` 7 when `tmr_flag` is 1.
- R7: `cond_sel` 8 is taken on synchronised `tpin0` = 1, and `cond_sel` 9 on `tpin0` = 0. `cond_sel` 10 is taken on synchronised `tpin1` = 1, and `cond_sel` 11 on `tpin1` = 0.
- R8: `cond_sel` 12 is taken when `ibf` is 0. `cond_sel` 13 is taken when `obf` is 1.
- R9: `cond_sel` 14 and 15 are never taken, whatever the other inputs are.
- R10: `done` is high in exactly the cycle after each cycle in which `req` is sampled high, and it is low otherwise. Back-to-back requests give back-to-back results.
- R11: A request sampled at the first or second rising edge after a test-pin change sees the old pin level. From the third edge on, the request sees the new level.
- R12: After reset, `done`, `taken` and `next_pc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Resolve request, one per cycle |
| cond_sel | input | 4 | Branch test selector |
| bit_idx | input | 3 | Accumulator bit for the bit test |
| acc | input | 8 | Accumulator |
| carry | input | 1 | Carry flag |
| uflag0 | input | 1 | User flag 0 |
| uflag1 | input | 1 | User flag 1 |
| tmr_flag | input | 1 | Timer overflow flag |
| tpin0 | input | 1 | Asynchronous test pin 0 |
| tpin1 | input | 1 | Asynchronous test pin 1 |
| ibf | input | 1 | Host input buffer full |
| obf | input | 1 | Host output buffer full |
| pc_in | input | 12 | Address of the jump opcode |
| target | input | 8 | Jump operand byte |
| done | output | 1 | Result valid |
| taken | output | 1 | Branch condition held |
| next_pc | output | 12 | Resolved next program counter |

## Verification
The assertions assume that the operands, the selector, `pc_in` and `target` are valid in every cycle in which `req` is high. They check the result against those operands as they were one cycle earlier. No property covers the test pins, because the pins may take any value during reset while the synchroniser is held clear. The stimulus changes the pins only at falling edges and works out their effect from the pin values applied two cycles before each request. Every other input is driven together with the request in the same half-cycle.

// File: rtl/pgbr_pkg.sv
package pgbr_pkg;

    typedef enum logic [3:0] {
        CND_ACC_ZERO  = 4'd0,
        CND_ACC_NZ    = 4'd1,
        CND_ACC_BIT   = 4'd2,
        CND_CY_SET    = 4'd3,
        CND_CY_CLR    = 4'd4,
        CND_UF0_SET   = 4'd5,
        CND_UF1_SET   = 4'd6,
        CND_TMR_SET   = 4'd7,
        CND_TP0_HI    = 4'd8,
        CND_TP0_LO    = 4'd9,
        CND_TP1_HI    = 4'd10,
        CND_TP1_LO    = 4'd11,
        CND_IBF_CLR   = 4'd12,
        CND_OBF_SET   = 4'd13
    } cond_e;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RESOLVE = 1'b1
    } fsm_e;

endpackage

// File: rtl/pgbr_sync.sv
module pgbr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pgbr_cond.sv
module pgbr_cond
    import pgbr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] acc,
    input  logic              carry,
    input  logic              uflag0,
    input  logic              uflag1,
    input  logic              tmr_flag,
    input  logic              tp0_s,
    input  logic              tp1_s,
    input  logic              ibf,
    input  logic              obf,
    output logic              cond_met
);

    logic acc_is_zero;
    logic acc_bit;

    assign acc_is_zero = (acc == '0);
    assign acc_bit     = acc[bit_idx];

    always_comb begin
        case (sel)
            CND_ACC_ZERO: cond_met = acc_is_zero;
            CND_ACC_NZ:   cond_met = !acc_is_zero;
            CND_ACC_BIT:  cond_met = acc_bit;
            CND_CY_SET:   cond_met = carry;
            CND_CY_CLR:   cond_met = !carry;
            CND_UF0_SET:  cond_met = uflag0;
            CND_UF1_SET:  cond_met = uflag1;
            CND_TMR_SET:  cond_met = tmr_flag;
            CND_TP0_HI:   cond_met = tp0_s;
            CND_TP0_LO:   cond_met = !tp0_s;
            CND_TP1_HI:   cond_met = tp1_s;
            CND_TP1_LO:   cond_met = !tp1_s;
            CND_IBF_CLR:  cond_met = !ibf;
            CND_OBF_SET:  cond_met = obf;
            default:      cond_met = 1'b0;
        endcase
    end

endmodule

// File: rtl/pgbr_nextpc.sv
module pgbr_nextpc #(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] target,
    input  logic              take,
    output logic [PC_W-1:0]   pc_out
);

    logic [PC_W-1:0] operand_addr;
    logic [PC_W-1:0] fall_addr;
    logic [PC_W-1:0] jump_addr;

    assign operand_addr = pc + PC_W'(1);
    assign fall_addr    = pc + PC_W'(2);
    assign jump_addr    = {operand_addr[PC_W-1:DATA_W], target};
    assign pc_out       = take ? jump_addr : fall_addr;

endmodule

// File: rtl/pgbr_unit.sv
module pgbr_unit
    import pgbr_pkg::*;
#(
    parameter int PC_W        = 12,
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(DATA_W),
    localparam int NPINS      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] acc,
    input  logic              carry,
    input  logic              uflag0,
    input  logic              uflag1,
    input  logic              tmr_flag,
    input  logic              tpin0,
    input  logic              tpin1,
    input  logic              ibf,
    input  logic              obf,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] target,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc
);

    fsm_e             state_q;
    fsm_e             state_d;
    logic [NPINS-1:0] pins_s;
    logic             cond_met;
    logic [PC_W-1:0]  pc_res;

    pgbr_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({tpin1, tpin0}),
        .sync_out (pins_s)
    );

    pgbr_cond #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cond (
        .sel      (cond_sel),
        .bit_idx  (bit_idx),
        .acc      (acc),
        .carry    (carry),
        .uflag0   (uflag0),
        .uflag1   (uflag1),
        .tmr_flag (tmr_flag),
        .tp0_s    (pins_s[0]),
        .tp1_s    (pins_s[1]),
        .ibf      (ibf),
        .obf      (obf),
        .cond_met (cond_met)
    );

    pgbr_nextpc #(.PC_W(PC_W), .DATA_W(DATA_W)) u_npc (
        .pc     (pc_in),
        .target (target),
        .take   (cond_met),
        .pc_out (pc_res)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_ACCEPT, T_WAIT, T_CHAIN, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = req ? ST_RESOLVE : ST_IDLE;
            ST_RESOLVE: state_d = req ? ST_RESOLVE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Registered outputs: capture on each accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            next_pc <= '0;
        end else if (req) begin
            taken   <= cond_met;
            next_pc <= pc_res;
        end
    end

    assign done = (state_q == ST_RESOLVE);

endmodule

// File: rtl/pgbr_chk.sv
module pgbr_chk #(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [SEL_W-1:0]  cond_sel,
    input logic [DATA_W-1:0] acc,
    input logic [PC_W-1:0]   pc_in,
    input logic [DATA_W-1:0] target,
    input logic              done,
    input logic              taken,
    input logic [PC_W-1:0]   next_pc
);

    logic [PC_W-1:0] opnd_addr;
    logic [PC_W-1:0] skip_addr;
    assign opnd_addr = pc_in + PC_W'(1);
    assign skip_addr = pc_in + PC_W'(2);

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done); // R10

    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !done); // R10

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!taken || next_pc == {$past(opnd_addr[PC_W-1:DATA_W]), $past(target)})); // R1

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (taken || next_pc == $past(skip_addr))); // R2

    AST_UNDEF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cond_sel >= SEL_W'(14)) |=> !taken); // R9

    AST_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cond_sel == SEL_W'(0)) |=> (taken == ($past(acc) == '0))); // R3

endmodule

bind pgbr_unit pgbr_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .cond_sel (cond_sel),
    .acc      (acc),
    .pc_in    (pc_in),
    .target   (target),
    .done     (done),
    .taken    (taken),
    .next_pc  (next_pc)
);

// File: tb/sim_pgbr_unit.sv
module sim_pgbr_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        tk;
        logic [11:0] pc;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [3:0] cond_sel = '0;
    logic [2:0] bit_idx = '0;
    logic [7:0] acc = '0;
    logic carry = 0, uflag0 = 0, uflag1 = 0, tmr_flag = 0;
    logic tpin0 = 0, tpin1 = 0, ibf = 0, obf = 0;
    logic [11:0] pc_in = '0;
    logic [7:0] target = '0;
    logic done, taken;
    logic [11:0] next_pc;

    // stimulus shadow
    logic [3:0] s_sel = '0; logic [2:0] s_idx = '0; logic [7:0] s_acc = '0;
    logic s_cy = 0, s_f0 = 0, s_f1 = 0, s_tf = 0, s_t0 = 0, s_t1 = 0, s_ibf = 0, s_obf = 0;
    logic [11:0] s_pc = '0; logic [7:0] s_tgt = '0;
    logic t0_m1 = 0, t0_m2 = 0, t1_m1 = 0, t1_m2 = 0;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgbr_unit u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .cond_sel(cond_sel), .bit_idx(bit_idx),
        .acc(acc), .carry(carry), .uflag0(uflag0), .uflag1(uflag1), .tmr_flag(tmr_flag),
        .tpin0(tpin0), .tpin1(tpin1), .ibf(ibf), .obf(obf), .pc_in(pc_in), .target(target),
        .done(done), .taken(taken), .next_pc(next_pc)
    );

    function automatic logic model_take(input logic e0, input logic e1);
        case (s_sel)
            4'd0:  return s_acc == 8'h00;
            4'd1:  return s_acc != 8'h00;
            4'd2:  return s_acc[s_idx];
            4'd3:  return s_cy;
            4'd4:  return !s_cy;
            4'd5:  return s_f0;
            4'd6:  return s_f1;
            4'd7:  return s_tf;
            4'd8:  return e0;
            4'd9:  return !e0;
            4'd10: return e1;
            4'd11: return !e1;
            4'd12: return !s_ibf;
            4'd13: return s_obf;
            default: return 1'b0;
        endcase
    endfunction

    // Driver: one cycle per call, pushes the expected result for a request
    task automatic tick(input bit do_req, input string tag);
        exp_t e;
        logic [11:0] opnd;
        @(negedge clk);
        req = do_req; cond_sel = s_sel; bit_idx = s_idx; acc = s_acc; carry = s_cy;
        uflag0 = s_f0; uflag1 = s_f1; tmr_flag = s_tf; tpin0 = s_t0; tpin1 = s_t1;
        ibf = s_ibf; obf = s_obf; pc_in = s_pc; target = s_tgt;
        if (do_req) begin
            opnd  = s_pc + 12'd1;
            e.tk  = model_take(t0_m2, t1_m2);
            e.pc  = e.tk ? {opnd[11:8], s_tgt} : s_pc + 12'd2;
            e.tag = tag;
            q.push_back(e);
        end
        t0_m2 = t0_m1; t0_m1 = s_t0;
        t1_m2 = t1_m1; t1_m1 = s_t1;
    endtask

    task automatic run(input logic [3:0] sel, input string tag);
        s_sel = sel;
        tick(1'b1, tag);
    endtask

    // Monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (mon_on) begin
                if (q.size() > 0) begin
                    e = q.pop_front();
                    n_chk++;
                    if (!done || taken !== e.tk || next_pc !== e.pc) begin
                        n_bad++;
                        $display("FAIL %s: done=%b taken=%b next_pc=%h expected done=1 taken=%b next_pc=%h",
                                 e.tag, done, taken, next_pc, e.tk, e.pc);
                    end
                end else begin
                    n_chk++;
                    if (done !== 1'b0) begin
                        n_bad++;
                        $display("FAIL R10: done=%b with no request, expected 0", done);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick(1'b0, "");
        rst_n = 1'b1;
        tick(1'b0, "");
        #1;
        n_chk++;
        if (done !== 1'b0 || taken !== 1'b0 || next_pc !== 12'h000) begin
            n_bad++;
            $display("FAIL R12: done=%b taken=%b next_pc=%h expected 0 0 000", done, taken, next_pc);
        end
        mon_on = 1;

        // R3 accumulator zero / non-zero
        s_pc = 12'h234; s_tgt = 8'h56;
        s_acc = 8'h00; run(4'd0, "R3 zero"); run(4'd1, "R3 nz");
        s_acc = 8'h80; run(4'd0, "R3 zero"); run(4'd1, "R3 nz");
        // R4 bit test
        s_acc = 8'hA5;
        for (int i = 0; i < 8; i++) begin s_idx = 3'(i); run(4'd2, "R4 bit"); end
        // R5 carry
        s_cy = 1; run(4'd3, "R5 cy"); run(4'd4, "R5 ncy");
        s_cy = 0; run(4'd3, "R5 cy"); run(4'd4, "R5 ncy");
        // R6 flags
        s_f0 = 1; run(4'd5, "R6 f0"); run(4'd6, "R6 f1");
        s_f0 = 0; s_f1 = 1; run(4'd5, "R6 f0"); run(4'd6, "R6 f1");
        run(4'd7, "R6 tf"); s_tf = 1; run(4'd7, "R6 tf");
        // R8 buffer flags
        s_ibf = 0; run(4'd12, "R8 ibf"); s_ibf = 1; run(4'd12, "R8 ibf");
        s_obf = 0; run(4'd13, "R8 obf"); s_obf = 1; run(4'd13, "R8 obf");
        // R9 undefined selectors with all inputs asserted
        s_acc = 8'hFF; s_cy = 1; s_f0 = 1; s_f1 = 1;
        run(4'd14, "R9 sel14"); run(4'd15, "R9 sel15");
        tick(1'b0, ""); tick(1'b0, "");
        // R7 settled pins
        s_t0 = 1; s_t1 = 0; repeat (3) tick(1'b0, "");
        run(4'd8, "R7 t0"); run(4'd9, "R7 nt0"); run(4'd10, "R7 t1"); run(4'd11, "R7 nt1");
        s_t0 = 0; s_t1 = 1; repeat (3) tick(1'b0, "");
        run(4'd8, "R7 t0"); run(4'd9, "R7 nt0"); run(4'd10, "R7 t1"); run(4'd11, "R7 nt1");
        // R11 synchroniser latency: change with request, then two more
        s_t0 = 1; run(4'd8, "R11 edge1"); run(4'd8, "R11 edge2"); run(4'd8, "R11 edge3");
        s_t1 = 0; run(4'd11, "R11 edge1"); run(4'd11, "R11 edge2"); run(4'd11, "R11 edge3");
        // R1 page edges
        s_cy = 1; s_tgt = 8'h3C;
        s_pc = 12'h0FE; run(4'd3, "R1 in page");
        s_pc = 12'h0FF; run(4'd3, "R1 next page");
        s_pc = 12'hFFF; run(4'd3, "R1 wrap page");
        s_pc = 12'h7FF; run(4'd3, "R1 mid page");
        // R2 fall-through wraps
        s_cy = 0;
        s_pc = 12'hFFE; run(4'd3, "R2 wrap");
        s_pc = 12'hFFF; run(4'd3, "R2 wrap");
        s_pc = 12'h0FF; run(4'd3, "R2 page");
        // R10 gaps between requests
        tick(1'b0, ""); run(4'd4, "R10 single"); tick(1'b0, ""); tick(1'b0, "");
        run(4'd4, "R10 pair"); run(4'd3, "R10 pair");
        repeat (4) tick(1'b0, "");
        finish_run();
    end

endmodule